// File: doc/BRIEF.md
# Time-Driven Crosspoint Configuration Scheduler

The block sets the input-to-output map of a crosspoint switching fabric on a fixed time grid. The grid is built from a one-pulse-per-second time reference. Each second is cut into a fixed number of frames, and each frame is a fixed number of clock cycles. The last few cycles of every frame form an idle guard gap, and the fabric map may change only inside that gap. A per-second schedule supplies one map for every frame slot. During the guard gap of each frame, the block loads the map of the following slot and drives it to the fabric.

Packet arrivals play no part in reconfiguration. A change comes only from the frame clock and the schedule that was loaded in advance.

The schedule is held twice, as an active table and a shadow table. A host fills the shadow table through a plain write port and then raises a commit pulse. The two tables trade places at the next second boundary, so every second runs from one complete table. If the reference pulse stops arriving, frames keep running on the local clock. A flag then reports that the time reference has been lost.

Top module: `xsched_top`

## Requirements
- R1: While reset is high, `cfg_sel`, `cfg_en`, `cfg_update`, `frame_idx`, `in_guard` and `sync_lost` are all zero.
- R2: A rising edge on `pps_in` sampled at a clock edge makes that edge start frame 0 at cycle 0. After that, `frame_idx` advances every FRAME_CYC cycles and wraps from FPS-1 to 0.
- R3: `in_guard` is high during the last GUARD_CYC cycles of each frame and low during the others.
- R4: In the first guard cycle of a frame, `cfg_update` is high for exactly one cycle. In that same cycle the map of the next slot (current slot plus one, wrapping to 0) appears on the outputs. It stays unchanged until the next update.
- R5: A schedule entry holds one field of SEL_W+1 bits per output port. Port p's field starts at bit p*(SEL_W+1). The low SEL_W bits of a field are the input select and the top bit is the enable. An output whose enable is 0 drives `cfg_en[p]`=0 and a select of 0.
- R6: Host writes go only to the shadow table. Maps that are already running do not change.
- R7: A `commit` pulse seen before the slot-0 lookup (frame FPS-1, cycle FRAME_CYC-GUARD_CYC-2) makes the shadow table active from the next frame 0 onward. This includes the map shown during frame 0 itself.
- R8: `sync_lost` rises when FPS+LOSS_FRAMES frame ends pass with no `pps_in` edge. It falls on the next edge. If an edge arrives at the same clock edge as the limit is reached, the edge wins and `sync_lost` stays low.
- R9: While `sync_lost` is high, frames keep counting on the local clock and the active schedule keeps being applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | One-pulse-per-second reference, synchronous to clk |
| wr_en | input | 1 | Host write strobe into the shadow table |
| wr_slot | input | SLOT_W | Frame slot written |
| wr_data | input | NPORT*(SEL_W+1) | Schedule entry |
| commit | input | 1 | Request to swap the tables at the next second boundary |
| cfg_sel | output | NPORT*SEL_W | Input select for each output port |
| cfg_en | output | NPORT | Enable for each output port |
| cfg_update | output | 1 | One-cycle strobe when a new map is applied |
| frame_idx | output | SLOT_W | Current frame slot within the second |
| in_guard | output | 1 | High during the guard gap |
| sync_lost | output | 1 | Time reference missing |

## Verification
Two events can land on the same clock edge: the reference pulse, and the frame end at which the missing-pulse counter reaches its limit. To provoke this, the bench withholds the pulse for exactly FPS+LOSS_FRAMES frames and then raises it on that frame end. It expects `sync_lost` to stay low and `frame_idx` to restart at 0. A later run withholds the pulse for one edge longer, and the flag must rise on that exact edge while maps keep being applied.

// File: rtl/xsched_pkg.sv
package xsched_pkg;
  // width of an index able to address v items, never below one bit
  function automatic int xs_w(input int v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/xsched_frame_timer.sv
module xsched_frame_timer #(
  parameter int FPS         = 4,
  parameter int FRAME_CYC   = 16,
  parameter int GUARD_CYC   = 4,
  parameter int LOSS_FRAMES = 2,
  parameter int SLOT_W      = 2,
  parameter int CYC_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pps_in,
  output logic [SLOT_W-1:0] frame_idx,
  output logic [SLOT_W-1:0] next_slot,
  output logic              in_guard,
  output logic              sync_lost,
  output logic              pps_rise,
  output logic              second_start,
  output logic              lookup
);
  localparam int GUARD_START = FRAME_CYC - GUARD_CYC;
  localparam int LOOK_AT     = GUARD_START - 2;
  localparam int LIM         = FPS + LOSS_FRAMES;
  localparam int CNT_W       = $clog2(LIM + 1);

  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [SLOT_W-1:0] frm_q, frm_d;
  logic [CNT_W-1:0]  miss_q, miss_d;
  logic              lost_q, lost_d;
  logic              pps_q, guard_q;
  logic              frame_end, last_frame;

  assign pps_rise     = pps_in & ~pps_q;
  assign frame_end    = (cyc_q == CYC_W'(FRAME_CYC - 1));
  assign last_frame   = (frm_q == SLOT_W'(FPS - 1));
  assign second_start = pps_rise | (frame_end & last_frame);
  assign next_slot    = last_frame ? '0 : frm_q + 1'b1;
  assign lookup       = ~pps_rise & (cyc_q == CYC_W'(LOOK_AT));

  always_comb begin
    cyc_d  = cyc_q + 1'b1;
    frm_d  = frm_q;
    miss_d = miss_q;
    lost_d = lost_q;
    if (pps_rise) begin
      cyc_d  = '0;
      frm_d  = '0;
      miss_d = '0;
      lost_d = 1'b0;
    end else if (frame_end) begin
      cyc_d = '0;
      frm_d = next_slot;
      if (miss_q != CNT_W'(LIM)) miss_d = miss_q + 1'b1;
      if (miss_q == CNT_W'(LIM - 1)) lost_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q   <= '0;
      frm_q   <= '0;
      miss_q  <= '0;
      lost_q  <= 1'b0;
      pps_q   <= 1'b0;
      guard_q <= 1'b0;
    end else begin
      cyc_q   <= cyc_d;
      frm_q   <= frm_d;
      miss_q  <= miss_d;
      lost_q  <= lost_d;
      pps_q   <= pps_in;
      guard_q <= (cyc_d >= CYC_W'(GUARD_START));
    end
  end

  assign frame_idx = frm_q;
  assign in_guard  = guard_q;
  assign sync_lost = lost_q;
endmodule

// File: rtl/xsched_table_ram.sv
module xsched_table_ram #(
  parameter int ENTRY_W = 12,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               we,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic               re,
  input  logic [ADDR_W-1:0]  raddr,
  output logic [ENTRY_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xsched_bank_ctrl.sv
module xsched_bank_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic commit,
  input  logic lookup,
  input  logic slot_zero,
  input  logic second_start,
  output logic active_bank,
  output logic rd_bank
);
  logic act_q, pend_q, armed_q;

  // the frame-0 map is read from the table that will be active in frame 0
  assign rd_bank     = (slot_zero & pend_q) ? ~act_q : act_q;
  assign active_bank = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (second_start) begin
      armed_q <= 1'b0;
      if (armed_q) begin
        act_q  <= ~act_q;
        pend_q <= commit;
      end else if (commit) begin
        pend_q <= 1'b1;
      end
    end else begin
      if (commit) pend_q <= 1'b1;
      if (lookup & slot_zero) armed_q <= pend_q;
    end
  end
endmodule

// File: rtl/xsched_map_drive.sv
module xsched_map_drive #(
  parameter int NPORT = 4,
  parameter int SEL_W = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_req,
  input  logic                       abort,
  input  logic [NPORT*(SEL_W+1)-1:0] entry,
  output logic [NPORT*SEL_W-1:0]     cfg_sel,
  output logic [NPORT-1:0]           cfg_en,
  output logic                       cfg_update
);
  localparam int FW = SEL_W + 1;

  logic ld_q, upd_q, take;

  assign take = ld_q & ~abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      ld_q  <= load_req;
      upd_q <= take;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [SEL_W-1:0] sel_r;
    logic             en_r;
    logic             f_en;

    assign f_en = entry[p*FW + SEL_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_r <= '0;
        en_r  <= 1'b0;
      end else if (take) begin
        en_r  <= f_en;
        sel_r <= f_en ? entry[p*FW +: SEL_W] : '0;
      end
    end

    assign cfg_sel[p*SEL_W +: SEL_W] = sel_r;
    assign cfg_en[p]                 = en_r;
  end

  assign cfg_update = upd_q;
endmodule

// File: rtl/xsched_top.sv
module xsched_top
  import xsched_pkg::*;
#(
  parameter int NPORT       = 4,
  parameter int FPS         = 4,
  parameter int FRAME_CYC   = 16,
  parameter int GUARD_CYC   = 4,
  parameter int LOSS_FRAMES = 2,
  localparam int SEL_W      = xs_w(NPORT),
  localparam int SLOT_W     = xs_w(FPS),
  localparam int ENTRY_W    = NPORT * (SEL_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pps_in,
  input  logic                   wr_en,
  input  logic [SLOT_W-1:0]      wr_slot,
  input  logic [ENTRY_W-1:0]     wr_data,
  input  logic                   commit,
  output logic [NPORT*SEL_W-1:0] cfg_sel,
  output logic [NPORT-1:0]       cfg_en,
  output logic                   cfg_update,
  output logic [SLOT_W-1:0]      frame_idx,
  output logic                   in_guard,
  output logic                   sync_lost
);
  localparam int CYC_W  = xs_w(FRAME_CYC);
  localparam int ADDR_W = SLOT_W + 1;

  logic [SLOT_W-1:0]  next_slot;
  logic               pps_rise, second_start, lookup;
  logic               active_bank, rd_bank;
  logic [ENTRY_W-1:0] rd_entry;

  xsched_frame_timer #(
    .FPS(FPS), .FRAME_CYC(FRAME_CYC), .GUARD_CYC(GUARD_CYC),
    .LOSS_FRAMES(LOSS_FRAMES), .SLOT_W(SLOT_W), .CYC_W(CYC_W)
  ) u_timer (
    .clk(clk), .rst(rst), .pps_in(pps_in),
    .frame_idx(frame_idx), .next_slot(next_slot), .in_guard(in_guard),
    .sync_lost(sync_lost), .pps_rise(pps_rise),
    .second_start(second_start), .lookup(lookup)
  );

  xsched_bank_ctrl u_bank (
    .clk(clk), .rst(rst), .commit(commit), .lookup(lookup),
    .slot_zero(next_slot == '0), .second_start(second_start),
    .active_bank(active_bank), .rd_bank(rd_bank)
  );

  xsched_table_ram #(.ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk),
    .we(wr_en), .waddr({~active_bank, wr_slot}), .wdata(wr_data),
    .re(lookup), .raddr({rd_bank, next_slot}), .rdata(rd_entry)
  );

  xsched_map_drive #(.NPORT(NPORT), .SEL_W(SEL_W)) u_drive (
    .clk(clk), .rst(rst), .load_req(lookup), .abort(pps_rise),
    .entry(rd_entry), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_update(cfg_update)
  );
endmodule

// File: rtl/xsched_checker.sv
module xsched_checker #(
  parameter int NPORT  = 4,
  parameter int FPS    = 4,
  parameter int SEL_W  = 2,
  parameter int SLOT_W = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   pps_in,
  input logic [NPORT*SEL_W-1:0] cfg_sel,
  input logic [NPORT-1:0]       cfg_en,
  input logic                   cfg_update,
  input logic [SLOT_W-1:0]      frame_idx,
  input logic                   in_guard,
  input logic                   sync_lost
);
  logic idle_bad;

  always_comb begin
    idle_bad = 1'b0;
    for (int p = 0; p < NPORT; p++)
      if (!cfg_en[p] && (cfg_sel[p*SEL_W +: SEL_W] != '0)) idle_bad = 1'b1;
  end

  assert_idle_port_R5: assert property (@(posedge clk) disable iff (rst)
    !idle_bad);

  assert_update_in_guard_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_update |-> in_guard);

  assert_update_single_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_update |=> !cfg_update);

  assert_map_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_update |-> ($stable(cfg_sel) && $stable(cfg_en)));

  assert_frame_range_R2: assert property (@(posedge clk) disable iff (rst)
    frame_idx <= SLOT_W'(FPS - 1));

  assert_pps_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (pps_in && !$past(pps_in)) |=> (frame_idx == '0));

  assert_lost_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (pps_in && !$past(pps_in)) |=> !sync_lost);
endmodule

bind xsched_top xsched_checker #(
  .NPORT(NPORT), .FPS(FPS), .SEL_W(SEL_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst(rst), .pps_in(pps_in), .cfg_sel(cfg_sel),
  .cfg_en(cfg_en), .cfg_update(cfg_update), .frame_idx(frame_idx),
  .in_guard(in_guard), .sync_lost(sync_lost)
);

// File: tb/xsched_top_test.sv
module xsched_top_test;
  localparam int NPORT = 4, FPS = 4, FC = 16, GC = 4, LOSS = 2;
  localparam int SEL_W = 2, SLOT_W = 2, FW = SEL_W + 1, ENTRY_W = NPORT * FW;
  localparam int GSTART = FC - GC;

  logic clk = 1'b0, rst = 1'b1, pps_in = 1'b0, wr_en = 1'b0, commit = 1'b0;
  logic [SLOT_W-1:0]      wr_slot = '0;
  logic [ENTRY_W-1:0]     wr_data = '0;
  logic [NPORT*SEL_W-1:0] cfg_sel;
  logic [NPORT-1:0]       cfg_en;
  logic                   cfg_update, in_guard, sync_lost;
  logic [SLOT_W-1:0]      frame_idx;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  xsched_top #(.NPORT(NPORT), .FPS(FPS), .FRAME_CYC(FC), .GUARD_CYC(GC),
               .LOSS_FRAMES(LOSS)) uut (
    .clk(clk), .rst(rst), .pps_in(pps_in), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(wr_data), .commit(commit), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_update(cfg_update), .frame_idx(frame_idx), .in_guard(in_guard),
    .sync_lost(sync_lost)
  );

  // table 0 = "A", table 1 = "B"; field layout per R5
  function automatic logic [ENTRY_W-1:0] mk_entry(input int tbl, input int s);
    logic [ENTRY_W-1:0] e = '0;
    for (int p = 0; p < NPORT; p++) begin
      int sel = (tbl == 0) ? (p + s + 1) % NPORT : (NPORT - 1 - p + s) % NPORT;
      logic en = (tbl == 0) ? !(s == 1 && p == 2) : !(s == 3 && p == 0);
      e[p*FW +: SEL_W] = SEL_W'(sel);
      e[p*FW + SEL_W]  = en;
    end
    return e;
  endfunction

  function automatic logic [NPORT*SEL_W-1:0] exp_sel(input logic [ENTRY_W-1:0] e);
    logic [NPORT*SEL_W-1:0] r = '0;
    for (int p = 0; p < NPORT; p++)
      if (e[p*FW + SEL_W]) r[p*SEL_W +: SEL_W] = e[p*FW +: SEL_W];
    return r;
  endfunction

  function automatic logic [NPORT-1:0] exp_en(input logic [ENTRY_W-1:0] e);
    logic [NPORT-1:0] r;
    for (int p = 0; p < NPORT; p++) r[p] = e[p*FW + SEL_W];
    return r;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_map(input string tag, input int tbl, input int s);
    check(tag, 32'(cfg_sel), 32'(exp_sel(mk_entry(tbl, s))));
    check(tag, 32'(cfg_en),  32'(exp_en(mk_entry(tbl, s))));
  endtask

  task automatic pps_pulse();
    pps_in = 1'b1; step(1); pps_in = 1'b0;
  endtask

  task automatic write_table(input int tbl);
    for (int s = 0; s < FPS; s++) begin
      wr_en = 1'b1; wr_slot = SLOT_W'(s); wr_data = mk_entry(tbl, s);
      step(1);
    end
    wr_en = 1'b0;
  endtask

  task automatic commit_pulse();
    commit = 1'b1; step(1); commit = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(3);
    check("R1 cfg_sel", 32'(cfg_sel), 0);
    check("R1 cfg_en", 32'(cfg_en), 0);
    check("R1 cfg_update", 32'(cfg_update), 0);
    check("R1 frame_idx", 32'(frame_idx), 0);
    check("R1 in_guard", 32'(in_guard), 0);
    check("R1 sync_lost", 32'(sync_lost), 0);
    rst = 1'b0;
  endtask

  // loads A, commits, and follows the second in which A is active
  task automatic t_commit_first();
    write_table(0);
    commit_pulse();
    pps_pulse();                 // P0
    step(FC*FPS - 1);
    pps_pulse();                 // P1: A active, frame 0 map is A[0]
    check("R7 frame0 from committed table", 32'(frame_idx), 0);
    check_map("R7 A0 at second start", 0, 0);
    step(GSTART - 1);
    check("R3 guard low before gap", 32'(in_guard), 0);
    check("R4 no strobe before gap", 32'(cfg_update), 0);
    step(1);                     // first guard cycle
    check("R4 strobe at first guard cycle", 32'(cfg_update), 1);
    check("R3 guard high", 32'(in_guard), 1);
    check_map("R4 next slot map A1", 0, 1);
    check("R5 disabled port 2 idle", 32'({cfg_en[2], cfg_sel[5:4]}), 0);
    check("R2 still frame 0 in gap", 32'(frame_idx), 0);
    step(1);
    check("R4 strobe one cycle", 32'(cfg_update), 0);
    step(GC - 1);                // frame 1 begins
    check("R2 frame advanced", 32'(frame_idx), 1);
    check("R3 guard low in new frame", 32'(in_guard), 0);
    check_map("R4 map held into frame", 0, 1);
  endtask

  // writes B into the shadow without commit: A keeps running
  task automatic t_shadow_only();
    write_table(1);                       // P1+16 .. P1+20
    step(8);
    check("R6 strobe frame1 gap", 32'(cfg_update), 1);
    check_map("R6 A2 after shadow writes", 0, 2);
    step(FC);
    check_map("R6 A3", 0, 3);
    step(FC);
    check_map("R6 A0 next second", 0, 0);
    step(3);
    pps_pulse();                          // P2
    check("R2 frame0 on pps", 32'(frame_idx), 0);
    check_map("R6 A0 held", 0, 0);
  endtask

  task automatic t_commit_second();
    commit_pulse();                       // P2+1
    step(FC*(FPS-1) + GSTART - 1);        // P2+60
    check("R7 strobe for frame 0 map", 32'(cfg_update), 1);
    check_map("R7 B0 loaded in last gap", 1, 0);
    step(GC - 1);
    pps_pulse();                          // P3
    check_map("R7 B0 in frame 0", 1, 0);
    step(GSTART);
    check_map("R7 B1 next", 1, 1);
  endtask

  task automatic t_sync();
    // now P3+12; the limit frame end falls at P3+96
    step(FC*(FPS+LOSS) - GSTART - 1);     // P3+95
    check("R8 not lost before limit", 32'(sync_lost), 0);
    pps_pulse();                          // pps on the limit edge: Q
    check("R8 pps wins over limit", 32'(sync_lost), 0);
    check("R2 frame0 on late pps", 32'(frame_idx), 0);
    step(FC*(FPS+LOSS) - 1);
    check("R8 not lost one edge early", 32'(sync_lost), 0);
    step(1);
    check("R8 lost at limit", 32'(sync_lost), 1);
    check("R9 free-running frame", 32'(frame_idx), 2);
    step(GSTART);
    check("R9 strobe while lost", 32'(cfg_update), 1);
    check_map("R9 schedule continues B3", 1, 3);
    pps_pulse();
    check("R8 cleared by pps", 32'(sync_lost), 0);
  endtask

  initial begin
    t_reset();
    t_commit_first();
    t_shadow_only();
    t_commit_second();
    t_sync();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule